// File: doc/BRIEF.md
# Configuration Port Lock Front End

This block sits behind a two-address, byte-wide host bus and guards a legacy controller's configuration space. Address 0 is the index port and address 1 is the data port. On reset the space is sealed. Writes to the index port are watched for the entry key, and nothing else reaches the registers. Once the key has been presented, an index write picks a configuration register, and data-port reads and writes then reach that register. A single exit byte written to the index port seals the space again.

Indices below 0x30 are global. They hold a device-select byte and read-only identity bytes. Indices from 0x30 up reach the small register file of the device that the select byte currently names. A built-in stub holds one such file for each device. Each host access is a one-cycle strobe, and the bus has no back-pressure. A read strobe loads `host_rdata` at the next clock edge, and the value then holds until the next read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is sealed, the index register is 0x00, the device select is 0x00 and `host_rdata` is 0xFF.
- R2: Two index-port writes of 0x87 in a row unseal the space. Data-port accesses between the two writes do not break the sequence.
- R3: After a first 0x87, an index-port write of any other byte drops the sequence back to its start. A single further 0x87 then leaves the space sealed.
- R4: While unsealed, an index-port write of 0xAA seals the space and leaves the index register unchanged.
- R5: While sealed, data-port writes change nothing, and reads on either port return 0xFF.
- R6: While unsealed, an index-port write of any byte other than 0xAA loads the index register, and an index-port read returns it.
- R7: Index 0x07 is the device select. It can be read and written through the data port.
- R8: Indices 0x20/0x21 return the device ID (high byte, then low byte), 0x22 returns the revision, and 0x23/0x24 return the vendor ID 0x1934. The defaults are ID 0x0B27 and revision 0x05. Writes to these indices are ignored.
- R9: All other indices from 0x00 to 0x2F read 0x00 and ignore writes, whatever the device select holds.
- R10: Index 0x30+k reaches byte k of the register file of the selected device. Each device keeps its own storage, and that storage resets to 0x00.
- R11: A device select at or beyond NUM_DEV, or an offset k at or beyond DEPTH, reads 0xFF and ignores writes.
- R12: `host_rdata` changes only on the clock edge that follows a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | 0 = index port, 1 = data port |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |

## Verification
The hardest state to reach is the half-open one. To get there, a first key must have been accepted, and the byte that follows must be neither the key nor absorbed as a new first key. The stimulus sends key, foreign byte, key, and then probes with reads, to show the space is still sealed before the final key opens it. A second hard case is a data write made while sealed. Its absence of effect can only be seen after unsealing, so the bench leaves a known value behind a retained index, relocks, writes over it, then reopens and reads it back.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {LK_CLOSED, LK_HALF, LK_OPEN} lock_state_e;

  localparam logic [7:0]  KEY_ENTER    = 8'h87;
  localparam logic [7:0]  KEY_EXIT     = 8'hAA;
  localparam logic [7:0]  IDX_DEVSEL   = 8'h07;
  localparam logic [7:0]  IDX_ID_HI    = 8'h20;
  localparam logic [7:0]  IDX_ID_LO    = 8'h21;
  localparam logic [7:0]  IDX_REV      = 8'h22;
  localparam logic [7:0]  IDX_VEND_HI  = 8'h23;
  localparam logic [7:0]  IDX_VEND_LO  = 8'h24;
  localparam logic [7:0]  IDX_DEV_BASE = 8'h30;
  localparam logic [15:0] VENDOR_ID    = 16'h1934;
  localparam logic [7:0]  SEALED_BYTE  = 8'hFF;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic       idx_load
);
  lock_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      case (st_q)
        LK_CLOSED: if (wdata == KEY_ENTER) st_d = LK_HALF;
        LK_HALF:   st_d = (wdata == KEY_ENTER) ? LK_OPEN : LK_CLOSED;
        LK_OPEN:   if (wdata == KEY_EXIT) st_d = LK_CLOSED;
        default:   st_d = LK_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= LK_CLOSED;
    else        st_q <= st_d;
  end

  assign open_o   = (st_q == LK_OPEN);
  assign idx_load = idx_wr && open_o && (wdata != KEY_EXIT);

  // R2: opening is always caused by a key byte on the index port
  a_r2_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(idx_wr && wdata == KEY_ENTER));

  // R3: a foreign second byte never opens the space
  a_r3_bad_second_key: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_HALF && idx_wr && wdata != KEY_ENTER) |=> !open_o);

  // R4: the exit byte seals
  a_r4_exit_seals: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && idx_wr && wdata == KEY_EXIT) |=> !open_o);
endmodule

// File: rtl/sio_glb_regs.sv
module sio_glb_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0B27,
  parameter logic [7:0]  DEV_REV = 8'h05
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_load,
  input  logic       glb_wr,
  input  logic [7:0] wdata,
  output logic [7:0] idx_o,
  output logic [7:0] devsel_o,
  output logic [7:0] rdata_o
);
  logic [7:0] idx_q, devsel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= 8'h00;
      devsel_q <= 8'h00;
    end else begin
      if (idx_load) idx_q <= wdata;
      if (glb_wr && idx_q == IDX_DEVSEL) devsel_q <= wdata;
    end
  end

  always_comb begin
    case (idx_q)
      IDX_DEVSEL:  rdata_o = devsel_q;
      IDX_ID_HI:   rdata_o = DEV_ID[15:8];
      IDX_ID_LO:   rdata_o = DEV_ID[7:0];
      IDX_REV:     rdata_o = DEV_REV;
      IDX_VEND_HI: rdata_o = VENDOR_ID[15:8];
      IDX_VEND_LO: rdata_o = VENDOR_ID[7:0];
      default:     rdata_o = 8'h00;
    endcase
  end

  assign idx_o    = idx_q;
  assign devsel_o = devsel_q;

  // R6: the index register moves only on an accepted index write
  a_r6_index_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> $past(idx_load));

  // R7: the device select moves only on a data write at its index
  a_r7_devsel_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(devsel_q) |-> $past(glb_wr && idx_q == IDX_DEVSEL));
endmodule

// File: rtl/sio_dev_stub.sv
module sio_dev_stub #(
  parameter int NUM_DEV = 8,
  parameter int DEPTH   = 16
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] devsel_i,
  input  logic [7:0] off_i,
  input  logic [7:0] wdata,
  output logic [7:0] rdata_o
);
  localparam int         DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int         OFF_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [8:0] NDEV_B  = 9'(NUM_DEV);
  localparam logic [8:0] DEPTH_B = 9'(DEPTH);

  logic             hit;
  logic [DEV_W-1:0] dsel;
  logic [OFF_W-1:0] off;
  logic [7:0]       dev_rd [NUM_DEV];

  assign hit  = ({1'b0, devsel_i} < NDEV_B) && ({1'b0, off_i} < DEPTH_B);
  assign dsel = devsel_i[DEV_W-1:0];
  assign off  = off_i[OFF_W-1:0];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [7:0] regs [DEPTH];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < DEPTH; k++) regs[k] <= 8'h00;
      end else if (wr && hit && dsel == DEV_W'(d)) begin
        regs[off] <= wdata;
      end
    end
    assign dev_rd[d] = regs[off];
  end

  assign rdata_o = hit ? dev_rd[dsel] : 8'hFF;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_DEV = 8,
  parameter int          DEPTH   = 16,
  parameter logic [15:0] DEV_ID  = 16'h0B27,
  parameter logic [7:0]  DEV_REV = 8'h05
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  logic       open, idx_load, idx_wr, dat_wr, in_dev;
  logic [7:0] idx, devsel, glb_rd, dev_rd, rd_next;

  assign idx_wr = host_wr && !host_addr;
  assign dat_wr = host_wr && host_addr && open;

  sio_key_fsm u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(host_wdata),
    .open_o(open), .idx_load(idx_load)
  );

  sio_glb_regs #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_glb (
    .clk(clk), .rst_n(rst_n), .idx_load(idx_load),
    .glb_wr(dat_wr && !in_dev), .wdata(host_wdata),
    .idx_o(idx), .devsel_o(devsel), .rdata_o(glb_rd)
  );

  assign in_dev = (idx >= IDX_DEV_BASE);

  sio_dev_stub #(.NUM_DEV(NUM_DEV), .DEPTH(DEPTH)) u_dev (
    .clk(clk), .rst_n(rst_n), .wr(dat_wr && in_dev), .devsel_i(devsel),
    .off_i(idx - IDX_DEV_BASE), .wdata(host_wdata), .rdata_o(dev_rd)
  );

  always_comb begin
    if (!open)          rd_next = SEALED_BYTE;
    else if (!host_addr) rd_next = idx;
    else if (in_dev)    rd_next = dev_rd;
    else                rd_next = glb_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= SEALED_BYTE;
    else if (host_rd) host_rdata <= rd_next;
  end

  // R5: sealed reads return all ones
  a_r5_sealed_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !open) |=> host_rdata == 8'hFF);

  // R12: read data holds between read strobes
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/sio_cfg_port_test.sv
`timescale 1ns/1ps
module sio_cfg_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sio_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  // behavioural reference model
  int m_lock;            // 0 sealed, 1 one key seen, 2 open
  int m_idx, m_sel, m_rd;
  int m_mem [8][16];

  function automatic int m_read(int a);
    if (m_lock != 2) return 255;
    if (a == 0) return m_idx;
    if (m_idx >= 48) begin
      if (m_sel < 8 && (m_idx - 48) < 16) return m_mem[m_sel][m_idx - 48];
      return 255;
    end
    case (m_idx)
      7: return m_sel;
      32: return 8'h0B;
      33: return 8'h27;
      34: return 8'h05;
      35: return 8'h19;
      36: return 8'h34;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = 0; m_idx = 0; m_sel = 0; m_rd = 255;
      foreach (m_mem[i, j]) m_mem[i][j] = 0;
    end else begin
      if (host_rd) m_rd = m_read(int'(host_addr));
      if (host_wr && !host_addr) begin
        if (m_lock == 2) begin
          if (host_wdata == 8'hAA) m_lock = 0; else m_idx = host_wdata;
        end else if (m_lock == 1) begin
          m_lock = (host_wdata == 8'h87) ? 2 : 0;
        end else if (host_wdata == 8'h87) m_lock = 1;
      end else if (host_wr && host_addr && m_lock == 2) begin
        if (m_idx == 7) m_sel = host_wdata;
        else if (m_idx >= 48 && m_sel < 8 && (m_idx - 48) < 16)
          m_mem[m_sel][m_idx - 48] = host_wdata;
      end
    end
  end

  // cycle-by-cycle comparison against the model (R12 timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(host_rdata) != m_rd) begin
        errors++;
        $display("FAIL R12 model: rdata actual %02h expected %02h", host_rdata, m_rd[7:0]);
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic rd_at(logic [7:0] i, output logic [7:0] d);
    wr(1'b0, i);
    rd(1'b1, d);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset rdata", host_rdata, 8'hFF);
    rd(1'b1, v); check("R5 sealed data read", v, 8'hFF);
    rd(1'b0, v); check("R5 sealed index read", v, 8'hFF);

    // R2 unlock with a data access between the keys
    wr(1'b0, 8'h87); rd(1'b1, v); wr(1'b0, 8'h87);
    rd(1'b0, v); check("R2/R1 open, index reset 00", v, 8'h00);
    rd_at(8'h07, v); check("R1 devsel reset", v, 8'h00);

    // R5 / R4: sealed data write ignored, index retained across relock
    wr(1'b0, 8'h30); wr(1'b1, 8'h11);
    wr(1'b0, 8'hAA);
    rd(1'b1, v); check("R4 sealed after exit", v, 8'hFF);
    wr(1'b1, 8'h99);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    rd(1'b0, v); check("R4 index kept", v, 8'h30);
    rd(1'b1, v); check("R5 sealed write ignored", v, 8'h11);

    // R3 broken sequence
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'h87); wr(1'b0, 8'h12); wr(1'b0, 8'h87);
    rd(1'b1, v); check("R3 still sealed", v, 8'hFF);
    wr(1'b0, 8'h87);
    rd(1'b0, v); check("R3 opens after fresh pair", v, 8'h30);

    // R6 index load and readback
    wr(1'b0, 8'h87);
    rd(1'b0, v); check("R6 index 87 loads when open", v, 8'h87);

    // R8 identity
    rd_at(8'h20, v); check("R8 id hi", v, 8'h0B);
    rd_at(8'h21, v); check("R8 id lo", v, 8'h27);
    rd_at(8'h22, v); check("R8 rev", v, 8'h05);
    rd_at(8'h23, v); check("R8 vendor hi", v, 8'h19);
    wr(1'b1, 8'h00); rd(1'b1, v); check("R8 vendor hi read-only", v, 8'h19);
    rd_at(8'h24, v); check("R8 vendor lo", v, 8'h34);

    // R7 devsel, R9 plain globals
    wr(1'b0, 8'h07); wr(1'b1, 8'h06); rd(1'b1, v); check("R7 devsel", v, 8'h06);
    wr(1'b0, 8'h10); wr(1'b1, 8'h5A); rd(1'b1, v); check("R9 plain global", v, 8'h00);
    wr(1'b0, 8'h07); wr(1'b1, 8'h00);
    rd_at(8'h10, v); check("R9 independent of devsel", v, 8'h00);

    // R10 per-device storage
    wr(1'b0, 8'h31); wr(1'b1, 8'hA1);
    wr(1'b0, 8'h07); wr(1'b1, 8'h06);
    rd_at(8'h31, v); check("R10 dev6 fresh", v, 8'h00);
    wr(1'b1, 8'hB6);
    wr(1'b0, 8'h07); wr(1'b1, 8'h00);
    rd_at(8'h31, v); check("R10 dev0 kept", v, 8'hA1);
    wr(1'b0, 8'h07); wr(1'b1, 8'h06);
    rd_at(8'h31, v); check("R10 dev6 kept", v, 8'hB6);
    rd_at(8'h3F, v); check("R10 last offset", v, 8'h00);

    // R11 out of range
    rd_at(8'h40, v); check("R11 offset beyond depth", v, 8'hFF);
    wr(1'b0, 8'h07); wr(1'b1, 8'h20);
    wr(1'b0, 8'h30); wr(1'b1, 8'h77);
    rd(1'b1, v); check("R11 device beyond range", v, 8'hFF);
    wr(1'b0, 8'h07); wr(1'b1, 8'h00);
    rd_at(8'h30, v); check("R11 write ignored", v, 8'h11);

    // R12 hold without strobes
    repeat (3) @(negedge clk);
    check("R12 rdata holds", host_rdata, 8'h11);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule